// File: doc/BRIEF.md
# Two-Operand Integer Execute Stage with Overflow Register

This block carries out the basic two-operand integer operations of a small word-oriented processor: copy, add, subtract, multiply, divide, remainder, left and right shift, and the three bitwise logic operations. Operand fetch has already happened when the stage is reached. The stage receives the destination value `a`, the source value `b`, an opcode and a flag that marks the destination as a literal. In the same cycle it returns the value to write back, together with a write strobe and the cycle cost of the operation.

An overflow register, one data word wide, sits inside the block and can be read at all times. Most arithmetic operations give it a new value. The rule differs by operation. Add sets a carry flag. Subtract sets an all-ones borrow mask. Multiply stores the high product word. Divide stores the binary fraction of the quotient. The two shifts store the bits that spill past either end of the word. The logic operations, the copy and the remainder leave the register unchanged. The register loads on a clock edge where `exec_en` is high. When the destination is a literal, the write strobe is held low but the overflow register still loads. A zero divisor gives defined zero results. The data width is a parameter, 16 by default.

Top module: `ovf_alu`

## Requirements
- R1: On a clock edge with `rst` high, `ovf_q` becomes zero.
- R2: `result_we` is high only when `exec_en` is high, the opcode is supported (1 to 11) and `dst_is_lit` is low. A literal destination does not stop the overflow update of an operation that defines one.
- R3: SET (opcode 1) returns `b`. AND (9), OR (10) and XOR (11) return the bitwise result of `a` and `b`. None of these four changes `ovf_q`.
- R4: ADD (opcode 2) returns (a+b) mod 2^W. `ovf_q` becomes 1 if a+b exceeds 2^W-1 and 0 otherwise.
- R5: SUB (opcode 3) returns (a-b) mod 2^W. `ovf_q` becomes all ones when b > a and zero otherwise.
- R6: MUL (opcode 4) returns the low W bits of a*b. `ovf_q` becomes the high W bits.
- R7: DIV (opcode 5) with b nonzero returns floor(a/b). `ovf_q` becomes floor(a*2^W/b) mod 2^W.
- R8: When b is zero, DIV and MOD return 0, DIV clears `ovf_q`, and MOD leaves `ovf_q` unchanged.
- R9: MOD (opcode 6) with b nonzero returns a mod b and leaves `ovf_q` unchanged.
- R10: SHL (opcode 7) returns (a<<b) mod 2^W. `ovf_q` becomes bits W to 2W-1 of a<<b. A shift amount of 2W or more gives zero for both.
- R11: SHR (opcode 8) returns a>>b. `ovf_q` becomes ((a*2^W)>>b) mod 2^W, which holds the bits shifted out below bit 0.
- R12: `cycles` reports 1 for SET, AND, OR and XOR; 2 for ADD, SUB, MUL, SHL and SHR; 3 for DIV and MOD; and 0 for unsupported opcodes (0 and 12 to 15).
- R13: When `exec_en` is low, or the opcode is unsupported, `result_we` is low and `ovf_q` keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute this cycle; lets the overflow register load |
| opcode | input | 4 | Operation select |
| opd_a | input | W | Destination operand value |
| opd_b | input | W | Source operand value |
| dst_is_lit | input | 1 | Destination is a literal, so the write is dropped |
| result | output | W | Write-back value |
| result_we | output | 1 | Write strobe for the destination |
| cycles | output | 2 | Cycle cost of the presented opcode |
| ovf_q | output | W | Overflow register |

## Verification
The only state in the block is the overflow register. A wrong next value, a missing load or a load that should not happen shows on `ovf_q` one edge after the operation. It stays there until a later operation that defines the register overwrites it. A wrong value can therefore be masked by the next ADD or MUL unless it is sampled straight away. For that reason the bench reads `ovf_q` after every operation and compares it with a running model. The long-division chain feeds the DIV quotient, the DIV fraction and the MOD remainder. An error at one stage corrupts some of these combinationally in the same cycle. The sweep runs every operand pair at a 4-bit width, so each of these values is checked for every input.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_SET  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_MUL  = 4'd4,
        OP_DIV  = 4'd5,
        OP_MOD  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_AND  = 4'd9,
        OP_BOR  = 4'd10,
        OP_XOR  = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        UNIT_LOGIC = 2'd0,
        UNIT_ARITH = 2'd1,
        UNIT_DIV   = 2'd2,
        UNIT_SHIFT = 2'd3
    } unit_e;

    typedef struct packed {
        logic       known;
        unit_e      unit;
        logic       ovf_load;
        logic [1:0] cost;
    } op_info_t;

    function automatic op_info_t decode_op(input logic [3:0] code);
        op_info_t info;
        info = '{known: 1'b1, unit: UNIT_LOGIC, ovf_load: 1'b0, cost: 2'd1};
        case (code)
            OP_SET, OP_AND, OP_BOR, OP_XOR: ;
            OP_ADD, OP_SUB, OP_MUL: begin
                info.unit = UNIT_ARITH; info.ovf_load = 1'b1; info.cost = 2'd2;
            end
            OP_DIV: begin
                info.unit = UNIT_DIV; info.ovf_load = 1'b1; info.cost = 2'd3;
            end
            OP_MOD: begin
                info.unit = UNIT_DIV; info.cost = 2'd3;
            end
            OP_SHL, OP_SHR: begin
                info.unit = UNIT_SHIFT; info.ovf_load = 1'b1; info.cost = 2'd2;
            end
            default: begin
                info.known = 1'b0; info.cost = 2'd0;
            end
        endcase
        return info;
    endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_BOR:  res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = b;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic [W-1:0] ovf
);
    localparam int PW = 2 * W;

    logic [W:0]    sum;
    logic [W:0]    diff;
    logic [PW-1:0] prod;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign diff = {1'b0, a} - {1'b0, b};
    assign prod = PW'(a) * PW'(b);

    always_comb begin
        case (op)
            OP_ADD: begin
                res = sum[W-1:0];
                ovf = W'(sum[W]);
            end
            OP_SUB: begin
                res = diff[W-1:0];
                ovf = {W{diff[W]}};
            end
            default: begin
                res = prod[W-1:0];
                ovf = prod[PW-1:W];
            end
        endcase
    end
endmodule

// File: rtl/alu_div_unit.sv
module alu_div_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo,
    output logic [W-1:0] frac,
    output logic [W-1:0] rem
);
    localparam int STEPS = 2 * W;

    logic [STEPS-1:0]      dividend;
    logic [STEPS-1:0]      qbits;
    logic [STEPS:0][W:0]   part;
    logic                  zero_div;

    assign dividend = {a, {W{1'b0}}};
    assign part[0]  = '0;
    assign zero_div = (b == '0);

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        logic [W:0] trial;
        logic       fits;
        assign trial = {part[s][W-1:0], dividend[STEPS-1-s]};
        assign fits  = (trial >= {1'b0, b});
        assign qbits[STEPS-1-s] = fits;
        assign part[s+1] = fits ? (trial - {1'b0, b}) : trial;
    end

    assign quo  = zero_div ? '0 : qbits[STEPS-1:W];
    assign frac = zero_div ? '0 : qbits[W-1:0];
    assign rem  = zero_div ? '0 : part[W][W-1:0];
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic [W-1:0] ovf
);
    localparam int PW = 2 * W;

    logic [PW-1:0] up;
    logic [PW-1:0] down;

    assign up   = {{W{1'b0}}, a} << b;
    assign down = {a, {W{1'b0}}} >> b;

    always_comb begin
        if (op == OP_SHL) begin
            res = up[W-1:0];
            ovf = up[PW-1:W];
        end else begin
            res = down[PW-1:W];
            ovf = down[W-1:0];
        end
    end
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec_en,
    input  logic [3:0]   opcode,
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic         dst_is_lit,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic [1:0]   cycles,
    output logic [W-1:0] ovf_q
);
    op_info_t     info;
    logic [W-1:0] logic_res;
    logic [W-1:0] arith_res, arith_ovf;
    logic [W-1:0] div_quo, div_frac, div_rem;
    logic [W-1:0] shift_res, shift_ovf;
    logic [W-1:0] ovf_next;

    assign info = decode_op(opcode);

    alu_logic_unit #(.W(W)) u_logic (
        .op(opcode), .a(opd_a), .b(opd_b), .res(logic_res)
    );

    alu_arith_unit #(.W(W)) u_arith (
        .op(opcode), .a(opd_a), .b(opd_b), .res(arith_res), .ovf(arith_ovf)
    );

    alu_div_unit #(.W(W)) u_div (
        .a(opd_a), .b(opd_b), .quo(div_quo), .frac(div_frac), .rem(div_rem)
    );

    alu_shift_unit #(.W(W)) u_shift (
        .op(opcode), .a(opd_a), .b(opd_b), .res(shift_res), .ovf(shift_ovf)
    );

    always_comb begin
        case (info.unit)
            UNIT_ARITH: begin
                result   = arith_res;
                ovf_next = arith_ovf;
            end
            UNIT_DIV: begin
                result   = (opcode == OP_MOD) ? div_rem : div_quo;
                ovf_next = div_frac;
            end
            UNIT_SHIFT: begin
                result   = shift_res;
                ovf_next = shift_ovf;
            end
            default: begin
                result   = logic_res;
                ovf_next = ovf_q;
            end
        endcase
    end

    assign result_we = exec_en && info.known && !dst_is_lit;
    assign cycles    = info.cost;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= '0;
        end else if (exec_en && info.ovf_load) begin
            ovf_q <= ovf_next;
        end
    end
endmodule

// File: rtl/ovf_alu_checks.sv
module ovf_alu_checks
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         exec_en,
    input logic [3:0]   opcode,
    input logic [W-1:0] opd_a,
    input logic [W-1:0] opd_b,
    input logic         dst_is_lit,
    input logic [W-1:0] result,
    input logic         result_we,
    input logic [1:0]   cycles,
    input logic [W-1:0] ovf_q
);
    logic keeps_ovf;
    assign keeps_ovf = (opcode == OP_SET) || (opcode == OP_AND) || (opcode == OP_BOR)
                    || (opcode == OP_XOR) || (opcode == OP_MOD) || (opcode == OP_NONE)
                    || (opcode > OP_XOR);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (ovf_q == '0));

    assert_literal_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        dst_is_lit |-> !result_we);

    assert_idle_no_write_R13: assert property (@(posedge clk) disable iff (rst)
        !exec_en |-> !result_we);

    assert_idle_holds_ovf_R13: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(ovf_q));

    assert_keepers_hold_ovf_R3: assert property (@(posedge clk) disable iff (rst)
        (exec_en && keeps_ovf) |=> $stable(ovf_q));

    assert_add_carry_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode == OP_ADD) |=> (ovf_q <= W'(1)));

    assert_sub_borrow_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode == OP_SUB) |=> (ovf_q == '0 || ovf_q == '1));

    assert_zero_div_result_R8: assert property (@(posedge clk) disable iff (rst)
        ((opcode == OP_DIV || opcode == OP_MOD) && opd_b == '0) |-> (result == '0));

    assert_zero_div_ovf_R8: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode == OP_DIV && opd_b == '0) |=> (ovf_q == '0));

    assert_div_cost_R12: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_DIV || opcode == OP_MOD) |-> (cycles == 2'd3));
endmodule

bind ovf_alu ovf_alu_checks #(.W(W)) u_ovf_alu_checks (
    .clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode),
    .opd_a(opd_a), .opd_b(opd_b), .dst_is_lit(dst_is_lit),
    .result(result), .result_we(result_we), .cycles(cycles), .ovf_q(ovf_q)
);

// File: tb/ovf_alu_bench.sv
`timescale 1ns/1ps
module ovf_alu_bench;
    localparam int W = 4;
    localparam int M = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         exec_en = 1'b0;
    logic [3:0]   opcode = '0;
    logic [W-1:0] opd_a = '0;
    logic [W-1:0] opd_b = '0;
    logic         dst_is_lit = 1'b0;
    logic [W-1:0] result;
    logic         result_we;
    logic [1:0]   cycles;
    logic [W-1:0] ovf_q;

    int total = 0;
    int bad = 0;
    int model_o = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ovf_alu #(.W(W)) u_ovf_alu (
        .clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode),
        .opd_a(opd_a), .opd_b(opd_b), .dst_is_lit(dst_is_lit),
        .result(result), .result_we(result_we), .cycles(cycles), .ovf_q(ovf_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (op=%0d a=%0d b=%0d lit=%0b)",
                     req, act, exp, opcode, opd_a, opd_b, dst_is_lit);
        end
    endtask

    function automatic int cost_of(input int op);
        if (op == 1 || op >= 9 && op <= 11) return 1;
        if (op >= 2 && op <= 4 || op == 7 || op == 8) return 2;
        if (op == 5 || op == 6) return 3;
        return 0;
    endfunction

    // Returns expected result; updates model_o for operations that load it.
    function automatic int model(input int op, input int a, input int b);
        int t;
        case (op)
            1:  return b;
            2:  begin t = a + b; model_o = (t > M) ? 1 : 0; return t & M; end
            3:  begin model_o = (b > a) ? M : 0; return (a - b) & M; end
            4:  begin t = a * b; model_o = (t >> W) & M; return t & M; end
            5:  begin
                    if (b == 0) begin model_o = 0; return 0; end
                    model_o = ((a << W) / b) & M; return a / b;
                end
            6:  return (b == 0) ? 0 : a % b;
            7:  begin t = (b >= 2 * W) ? 0 : (a << b); model_o = (t >> W) & M; return t & M; end
            8:  begin model_o = ((a << W) >> b) & M; return a >> b; end
            9:  return a & b;
            10: return a | b;
            11: return a ^ b;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int op, input int b);
        if ((op == 5 || op == 6) && b == 0) return "R8";
        case (op)
            1, 9, 10, 11: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R9";
            7: return "R10";
            8: return "R11";
            default: return "R13";
        endcase
    endfunction

    // Drive one operation at a negedge, check comb outputs, then ovf_q after the edge.
    task automatic run_op(input int op, input int a, input int b, input bit lit, input bit en);
        int exp_r;
        int exp_o;
        bit known;
        known = (op >= 1 && op <= 11);
        opcode = 4'(op); opd_a = W'(a); opd_b = W'(b); dst_is_lit = lit; exec_en = en;
        exp_o = model_o;
        exp_r = model(op, a, b);
        if (!en) model_o = exp_o;
        #1;
        check(result_we == (en && known && !lit), "R2", int'(result_we), int'(en && known && !lit));
        if (en && known && !lit)
            check(int'(result) == exp_r, tag_of(op, b), int'(result), exp_r);
        if (en)
            check(int'(cycles) == cost_of(op), "R12", int'(cycles), cost_of(op));
        @(posedge clk);
        @(negedge clk);
        check(int'(ovf_q) == model_o, en ? tag_of(op, b) : "R13", int'(ovf_q), model_o);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(ovf_q == '0, "R1", int'(ovf_q), 0);
        model_o = 0;

        // Exhaustive sweep: every opcode, operand pair and literal flag.
        for (int op = 0; op < 16; op++)
            for (int a = 0; a <= M; a++)
                for (int b = 0; b <= M; b++)
                    for (int lit = 0; lit < 2; lit++)
                        run_op(op, a, b, lit[0], 1'b1);

        // R13: with exec_en low nothing is written and the register holds.
        run_op(4, 15, 15, 1'b0, 1'b1);
        for (int op = 1; op < 12; op++)
            run_op(op, 7, 3, 1'b0, 1'b0);

        // R2: literal destination still loads the overflow register.
        run_op(2, 15, 1, 1'b1, 1'b1);
        check(ovf_q == W'(1), "R2", int'(ovf_q), 1);

        // R1: a reset in the middle of a run clears a nonzero register.
        run_op(3, 0, 1, 1'b0, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_o = 0;
        check(ovf_q == '0, "R1", int'(ovf_q), 0);

        finished = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!finished && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule